// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

The walker reads DMA descriptors from memory and follows a chain of descriptor blocks. Each descriptor takes 32 bytes and is read as eight 32-bit words over a request/acknowledge read port, where each word may take any number of cycles. The walker then unpacks the words into a 64-bit source address, a 64-bit destination address, a 28-bit byte count, an end-of-packet marker and an interrupt request. It offers these to a transfer engine on a valid/ready handshake and waits for the engine's completion pulse before it chooses the next descriptor.

Inside a block, descriptors lie next to each other in memory. A small remaining-count field in each descriptor tells the walker whether to step 32 bytes forward or to follow the descriptor's link pointer to another block. A stop marker ends the walk once that descriptor's transfer has completed. Software supplies a start address, the descriptor count of the first block and a start pulse. The walker rejects misaligned pointers, a sequential step that would leave a 4 KB page, and a first block whose count fields disagree with the count software gave.

Top module: `sg_desc_walker`

## Requirements
- R1: Reset state: busy, err, irq, mem_req and dsc_valid are low, and desc_count is zero.
- R2: A fetch issues eight reads in ascending order at the descriptor address plus 0, 4, 8 and so on up to 28. Each mem_req is held with a stable address until mem_ack; the read data is taken in the cycle of mem_ack, and the latency may vary.
- R3: Word fields: length = {word0[4:0], word1[31:9]}; word1[0] requests an interrupt, word1[1] is stop, word1[2] is end-of-packet, word1[8:3] is the remaining count; source = {word2, word3}, destination = {word4, word5}, link = {word6, word7}, with the high word first.
- R4: dsc_valid stays high with stable fields until dsc_ready. After the handshake, no further descriptor is offered or fetched until xfer_done.
- R5: After xfer_done, a nonzero remaining count makes the next descriptor address the current one plus 32. A zero count makes it the link address.
- R6: After the xfer_done of a descriptor with the stop marker set, whatever its remaining count, no further read is issued and busy falls. A new start is accepted afterwards.
- R7: irq goes high for exactly one cycle, in the cycle after xfer_done, when the completed descriptor requested it. Otherwise irq stays low.
- R8: busy rises in the cycle after an accepted start. A start pulse while busy has no effect on the walk.
- R9: A start address or link address with any of bits [4:0] set raises err, leaves busy low and issues no read.
- R10: A nonzero remaining count at a descriptor whose 32-byte step would enter a new 4 KB page raises err after its xfer_done, with no further read.
- R11: In the first block, the descriptor at position i (counting from 0) must carry remaining count first_count-1-i. A mismatch raises err once that descriptor's fetch ends, and it is never offered.
- R12: desc_count increments by one on each xfer_done. An accepted start clears it together with err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while not busy |
| start_addr | input | 64 | Address of the first descriptor |
| first_count | input | 7 | Number of descriptors in the first block |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 64 | Word read address |
| mem_ack | input | 1 | Read acknowledge, data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| dsc_valid | output | 1 | Descriptor offered to the transfer engine |
| dsc_ready | input | 1 | Transfer engine accepts the descriptor |
| dsc_src | output | 64 | Source address |
| dsc_dst | output | 64 | Destination address |
| dsc_len | output | 28 | Byte count |
| dsc_eop | output | 1 | End-of-packet marker |
| dsc_irq_req | output | 1 | Descriptor asks for an interrupt on completion |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| irq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | Walk in progress |
| err | output | 1 | Walk aborted on a pointer, page or count error |
| desc_count | output | 16 | Descriptors completed since the last start |

## Verification
The hardest situation to reach is a walk that crosses block boundaries while the memory answers with a different latency on every word and the engine stalls both ready and done. Only then do the sequential step, the link jump and the first-block count check all meet the handshake timing. The stimulus builds random multi-block lists in memory, each block placed at a random slot that fits inside its page, and draws the read latency, ready delay and done delay for every transfer. The page-crossing error needs a descriptor in the last 32-byte slot of a page with a nonzero count, so it is built as a directed case, and so are the misaligned start, the misaligned link and the count mismatch.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int SGW_AW    = 64;
  localparam int SGW_DW    = 32;
  localparam int SGW_NW    = 8;
  localparam int SGW_LW    = 28;
  localparam int SGW_RW    = 6;
  localparam int SGW_DSH   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT,
    ST_NEXT,
    ST_HALT
  } walk_state_t;

  typedef struct packed {
    logic [SGW_AW-1:0] src;
    logic [SGW_AW-1:0] dst;
    logic [SGW_AW-1:0] link;
    logic [SGW_LW-1:0] len;
    logic [SGW_RW-1:0] rem;
    logic              eop;
    logic              stop;
    logic              irq;
  } desc_t;

  function automatic desc_t unpack_desc(input logic [SGW_NW-1:0][SGW_DW-1:0] w);
    desc_t d;
    d.len  = {w[0][4:0], w[1][31:9]};
    d.rem  = w[1][8:3];
    d.eop  = w[1][2];
    d.stop = w[1][1];
    d.irq  = w[1][0];
    d.src  = {w[2], w[3]};
    d.dst  = {w[4], w[5]};
    d.link = {w[6], w[7]};
    return d;
  endfunction

endpackage

// File: rtl/sgw_rst_sync.sv
module sgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/sgw_fetch.sv
module sgw_fetch #(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int NW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [AW-1:0]          base,
  output logic                   mem_req,
  output logic [AW-1:0]          mem_addr,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   done,
  output logic [NW-1:0][DW-1:0]  words
);

  localparam int IW  = $clog2(NW);
  localparam int BSH = $clog2(DW/8);
  localparam logic [IW-1:0] LAST = IW'(NW-1);

  logic          active_q, active_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] base_q, base_d;
  logic          done_q, done_d;
  logic          take;

  assign take = active_q && mem_ack;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    base_d   = base_q;
    done_d   = 1'b0;
    if (go) begin
      active_d = 1'b1;
      idx_d    = '0;
      base_d   = base;
    end else if (take) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      base_q   <= base_d;
      done_q   <= done_d;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic          w_en;
    logic [DW-1:0] w_q;
    assign w_en = take && (idx_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= mem_rdata;
    end
    assign words[g] = w_q;
  end

  assign mem_req  = active_q;
  assign mem_addr = base_q + (AW'(idx_q) << BSH);
  assign done     = done_q;

endmodule

// File: rtl/sgw_next.sv
module sgw_next #(
  parameter int AW         = 64,
  parameter int RW         = 6,
  parameter int DSC_SHIFT  = 5,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [AW-1:0] cur,
  input  logic [RW-1:0] rem,
  input  logic [AW-1:0] link,
  output logic [AW-1:0] nxt,
  output logic          seq,
  output logic          page_cross,
  output logic          link_misal
);

  localparam logic [AW-1:0] STEP = AW'(1) << DSC_SHIFT;

  logic [AW-1:0] seq_addr;

  assign seq        = (rem != '0);
  assign seq_addr   = cur + STEP;
  assign page_cross = seq && (seq_addr[AW-1:PAGE_SHIFT] != cur[AW-1:PAGE_SHIFT]);
  assign link_misal = !seq && (link[DSC_SHIFT-1:0] != '0);
  assign nxt        = seq ? seq_addr : link;

endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker
  import sgw_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [63:0]          start_addr,
  input  logic [6:0]           first_count,
  output logic                 mem_req,
  output logic [63:0]          mem_addr,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic                 dsc_valid,
  input  logic                 dsc_ready,
  output logic [63:0]          dsc_src,
  output logic [63:0]          dsc_dst,
  output logic [27:0]          dsc_len,
  output logic                 dsc_eop,
  output logic                 dsc_irq_req,
  input  logic                 xfer_done,
  output logic                 irq,
  output logic                 busy,
  output logic                 err,
  output logic [CNT_W-1:0]     desc_count
);

  localparam int FCW = SGW_RW + 1;

  logic rst_s_n;

  sgw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  walk_state_t                  state_q, state_d;
  logic [SGW_AW-1:0]            cur_q, cur_d;
  desc_t                        desc_q, desc_d;
  logic [FCW-1:0]               exp_q, exp_d;
  logic                         first_q, first_d;
  logic                         err_q, err_d;
  logic                         irq_q, irq_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;

  logic                         go;
  logic [SGW_AW-1:0]            go_addr;
  logic                         f_done;
  logic [SGW_NW-1:0][SGW_DW-1:0] f_words;
  desc_t                        f_desc;
  logic [SGW_AW-1:0]            nxt_addr;
  logic                         nxt_seq, nxt_cross, nxt_misal;

  sgw_fetch #(.AW(SGW_AW), .DW(SGW_DW), .NW(SGW_NW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .go        (go),
    .base      (go_addr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (f_done),
    .words     (f_words)
  );

  sgw_next #(.AW(SGW_AW), .RW(SGW_RW), .DSC_SHIFT(SGW_DSH), .PAGE_SHIFT(PAGE_SHIFT)) u_next (
    .cur        (cur_q),
    .rem        (desc_q.rem),
    .link       (desc_q.link),
    .nxt        (nxt_addr),
    .seq        (nxt_seq),
    .page_cross (nxt_cross),
    .link_misal (nxt_misal)
  );

  assign f_desc = unpack_desc(f_words);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    desc_d  = desc_q;
    exp_d   = exp_q;
    first_d = first_q;
    err_d   = err_q;
    irq_d   = 1'b0;
    cnt_d   = cnt_q;
    go      = 1'b0;
    go_addr = cur_q;
    unique case (state_q)
      ST_IDLE, ST_HALT: begin
        if (start) begin
          cnt_d = '0;
          err_d = 1'b0;
          if (start_addr[SGW_DSH-1:0] != '0) begin
            err_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            go      = 1'b1;
            go_addr = start_addr;
            cur_d   = start_addr;
            exp_d   = first_count - 1'b1;
            first_d = 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (f_done) begin
          desc_d = f_desc;
          if (first_q && ({1'b0, f_desc.rem} != exp_q)) begin
            err_d   = 1'b1;
            state_d = ST_HALT;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (dsc_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (xfer_done) begin
          cnt_d   = cnt_q + 1'b1;
          irq_d   = desc_q.irq;
          state_d = desc_q.stop ? ST_HALT : ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (nxt_cross || nxt_misal) begin
          err_d   = 1'b1;
          state_d = ST_HALT;
        end else begin
          go      = 1'b1;
          go_addr = nxt_addr;
          cur_d   = nxt_addr;
          if (nxt_seq) exp_d   = exp_q - 1'b1;
          else         first_d = 1'b0;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      desc_q  <= '0;
      exp_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      desc_q  <= desc_d;
      exp_q   <= exp_d;
      first_q <= first_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dsc_valid   = (state_q == ST_ISSUE);
  assign dsc_src     = desc_q.src;
  assign dsc_dst     = desc_q.dst;
  assign dsc_len     = desc_q.len;
  assign dsc_eop     = desc_q.eop;
  assign dsc_irq_req = desc_q.irq;
  assign busy        = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign err         = err_q;
  assign irq         = irq_q;
  assign desc_count  = cnt_q;

endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic        dsc_valid,
  input logic        dsc_ready,
  input logic [63:0] dsc_src,
  input logic [63:0] dsc_dst,
  input logic [27:0] dsc_len,
  input logic        irq,
  input logic        busy,
  input logic        err
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && !dsc_ready) |=> (dsc_valid && $stable(dsc_src) && $stable(dsc_dst) && $stable(dsc_len))); // R4

  AST_NO_FETCH_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> !mem_req); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !dsc_valid)); // R6

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R9

endmodule

bind sg_desc_walker sgw_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .dsc_valid (dsc_valid),
  .dsc_ready (dsc_ready),
  .dsc_src   (dsc_src),
  .dsc_dst   (dsc_dst),
  .dsc_len   (dsc_len),
  .irq       (irq),
  .busy      (busy),
  .err       (err)
);

// File: tb/tb_sg_desc_walker.sv
`timescale 1ns/1ps
module tb_sg_desc_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] start_addr;
  logic [6:0]  first_count;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        dsc_valid;
  logic        dsc_ready;
  logic [63:0] dsc_src;
  logic [63:0] dsc_dst;
  logic [27:0] dsc_len;
  logic        dsc_eop;
  logic        dsc_irq_req;
  logic        xfer_done;
  logic        irq;
  logic        busy;
  logic        err;
  logic [15:0] desc_count;

  sg_desc_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .first_count(first_count), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .dsc_valid(dsc_valid),
    .dsc_ready(dsc_ready), .dsc_src(dsc_src), .dsc_dst(dsc_dst),
    .dsc_len(dsc_len), .dsc_eop(dsc_eop), .dsc_irq_req(dsc_irq_req),
    .xfer_done(xfer_done), .irq(irq), .busy(busy), .err(err),
    .desc_count(desc_count)
  );

  always #10 clk = ~clk;

  int  n_total = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  logic [31:0] mem [logic [63:0]];
  logic [63:0] rd_log [$];

  logic [63:0] e_src  [$];
  logic [63:0] e_dst  [$];
  logic [27:0] e_len  [$];
  logic        e_eop  [$];
  logic        e_irq  [$];
  logic        e_stop [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory responder with random latency
  initial begin
    int lat;
    lat = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        lat = int'($urandom % 4);
      end else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          mem_rdata = rd(mem_addr);
          rd_log.push_back(mem_addr);
        end else lat--;
      end
    end
  end

  task automatic clear_list();
    mem.delete();
    rd_log.delete();
    e_src.delete(); e_dst.delete(); e_len.delete();
    e_eop.delete(); e_irq.delete(); e_stop.delete();
  endtask

  // R3 word layout
  task automatic put_desc(input logic [63:0] a, input logic [63:0] s, input logic [63:0] d,
                          input logic [27:0] l, input bit eop, input bit iq, input bit stp,
                          input logic [5:0] rem, input logic [63:0] lnk);
    mem[a]      = {27'h0, l[27:23]};
    mem[a + 4]  = {l[22:0], rem, eop, stp, iq};
    mem[a + 8]  = s[63:32];
    mem[a + 12] = s[31:0];
    mem[a + 16] = d[63:32];
    mem[a + 20] = d[31:0];
    mem[a + 24] = lnk[63:32];
    mem[a + 28] = lnk[31:0];
    e_src.push_back(s); e_dst.push_back(d); e_len.push_back(l);
    e_eop.push_back(eop); e_irq.push_back(iq); e_stop.push_back(stp);
  endtask

  task automatic pulse_start(input logic [63:0] a, input logic [6:0] fc);
    @(negedge clk);
    start = 1'b1; start_addr = a; first_count = fc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output bit ok);
    int n;
    n = 0;
    while (!dsc_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    ok = dsc_valid;
  endtask

  task automatic serve_all(input bit poke);
    for (int k = 0; k < e_src.size(); k++) begin
      bit ok;
      int dly;
      wait_valid(ok);
      chk("R4 descriptor offered", {63'h0, ok}, 64'h1);
      if (!ok) return;
      chk("R3 source", dsc_src, e_src[k]);
      chk("R3 destination", dsc_dst, e_dst[k]);
      chk("R3 length", {36'h0, dsc_len}, {36'h0, e_len[k]});
      chk("R3 eop and irq flags", {62'h0, dsc_eop, dsc_irq_req}, {62'h0, e_eop[k], e_irq[k]});
      dly = int'($urandom % 4);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk("R4 offer held", {63'h0, dsc_valid}, 64'h1);
      end
      dsc_ready = 1'b1;
      @(negedge clk);
      dsc_ready = 1'b0;
      chk("R4 offer withdrawn", {63'h0, dsc_valid}, 64'h0);
      dly = 1 + int'($urandom % 5);
      for (int i = 0; i < dly; i++) begin
        if (poke && k == 0 && i == 0) begin
          start = 1'b1; start_addr = 64'h40; first_count = 7'd1;
        end else start = 1'b0;
        @(negedge clk);
        chk("R4 no fetch before done", {63'h0, mem_req}, 64'h0);
      end
      start = 1'b0;
      chk("R8 busy during walk", {63'h0, busy}, 64'h1);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk("R7 irq after done", {63'h0, irq}, {63'h0, e_irq[k]});
      chk("R12 count", {48'h0, desc_count}, 64'(k + 1));
      if (e_stop[k]) chk("R6 busy low after stop", {63'h0, busy}, 64'h0);
      @(negedge clk);
      chk("R7 irq single cycle", {63'h0, irq}, 64'h0);
    end
  endtask

  task automatic quiet_check(input string req, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req || dsc_valid) seen++;
    end
    chk(req, 64'(seen), 64'h0);
  endtask

  task automatic wait_err(input string req, output int offers);
    int n;
    n = 0;
    offers = 0;
    while (!err && n < 500) begin
      @(negedge clk);
      if (dsc_valid) offers++;
      n++;
    end
    chk(req, {63'h0, err}, 64'h1);
    chk(req, {63'h0, busy}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int offers;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; start_addr = '0; first_count = '0;
    dsc_ready = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset outputs", {59'h0, busy, err, irq, mem_req, dsc_valid}, 64'h0);
    chk("R1 reset count", {48'h0, desc_count}, 64'h0);

    // single stop descriptor with nonzero count: stop wins over the step (R6), read order (R2)
    clear_list();
    put_desc(64'h0000_0005_0000_2040, 64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00,
             28'hABCDEF1, 1'b1, 1'b1, 1'b1, 6'd2, 64'h0);
    pulse_start(64'h0000_0005_0000_2040, 7'd3);
    chk("R8 busy after start", {63'h0, busy}, 64'h1);
    serve_all(1'b0);
    chk("R2 read count", 64'(rd_log.size()), 64'd8);
    for (int i = 0; i < 8 && i < rd_log.size(); i++)
      chk("R2 read address order", rd_log[i], 64'h0000_0005_0000_2040 + 64'(4 * i));
    quiet_check("R6 no read after stop", 20);

    // random multi-block lists (R5 step and link), start ignored while busy (R8)
    for (int t = 0; t < 8; t++) begin
      int nb;
      int cnt [4];
      logic [63:0] bb [4];
      int total;
      clear_list();
      nb = 1 + int'($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        int slot;
        cnt[b] = 1 + int'($urandom % 5);
        slot = int'($urandom % (128 - cnt[b] + 1));
        bb[b] = {24'h0, 8'(t + 1), 20'(16 * t + 3 * b + 1), 12'h0} + 64'(slot * 32);
      end
      total = 0;
      for (int b = 0; b < nb; b++) begin
        for (int j = 0; j < cnt[b]; j++) begin
          bit last;
          logic [63:0] lnk;
          last = (b == nb - 1) && (j == cnt[b] - 1);
          if (j == cnt[b] - 1 && !last) lnk = bb[b + 1];
          else lnk = {$urandom, $urandom} & ~64'h1F;
          put_desc(bb[b] + 64'(32 * j), {$urandom, $urandom}, {$urandom, $urandom},
                   28'($urandom), 1'($urandom), 1'($urandom), last, 6'(cnt[b] - 1 - j), lnk);
          total++;
        end
      end
      pulse_start(bb[0], 7'(cnt[0]));
      serve_all(t == 0);
      chk("R12 final count", {48'h0, desc_count}, 64'(total));
      chk("R6 no error on clean walk", {63'h0, err}, 64'h0);
      quiet_check("R6 idle after walk", 10);
    end

    // R9 misaligned start
    clear_list();
    pulse_start(64'h0000_0000_0000_3008, 7'd1);
    chk("R9 misaligned start err", {63'h0, err}, 64'h1);
    chk("R9 misaligned start busy", {63'h0, busy}, 64'h0);
    chk("R12 count cleared by start", {48'h0, desc_count}, 64'h0);
    quiet_check("R9 no read for misaligned start", 10);

    // R10 sequential step leaving a page
    clear_list();
    put_desc(64'h0000_0000_1000_0FE0, 64'h10, 64'h20, 28'h40, 1'b0, 1'b0, 1'b0, 6'd1, 64'h0);
    pulse_start(64'h0000_0000_1000_0FE0, 7'd2);
    chk("R12 err cleared by start", {63'h0, err}, 64'h0);
    serve_all(1'b0);
    @(negedge clk);
    chk("R10 page crossing err", {63'h0, err}, 64'h1);
    chk("R10 page crossing busy", {63'h0, busy}, 64'h0);
    quiet_check("R10 no read past page", 10);

    // R9 misaligned link
    clear_list();
    put_desc(64'h0000_0000_2000_0100, 64'h30, 64'h50, 28'h80, 1'b1, 1'b0, 1'b0, 6'd0, 64'h0000_0000_2000_0204);
    pulse_start(64'h0000_0000_2000_0100, 7'd1);
    serve_all(1'b0);
    @(negedge clk);
    chk("R9 misaligned link err", {63'h0, err}, 64'h1);
    quiet_check("R9 no read at bad link", 10);

    // R11 first block count mismatch
    clear_list();
    put_desc(64'h0000_0000_3000_0000, 64'h1, 64'h2, 28'h3, 1'b0, 1'b0, 1'b0, 6'd0, 64'h0000_0000_3000_1000);
    pulse_start(64'h0000_0000_3000_0000, 7'd3);
    wait_err("R11 count mismatch err", offers);
    chk("R11 mismatched descriptor not offered", 64'(offers), 64'h0);
    quiet_check("R11 halted after mismatch", 10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule